// File: doc/BRIEF.md
# Receive Frame Buffer with Host Lockout

This block holds one received radio frame for a host to read. The frame arrives as a byte stream framed by a start pulse and an end pulse, and the link-quality and signal-strength bytes come with the end pulse. The store is a byte array that the host sees at a fixed base address. Offset 0 holds the frame length. The frame bytes follow, and the link-quality and signal-strength bytes sit right after the last frame byte.

When a frame is stored in full, a receive-done status bit is set and drives an interrupt line, unless the host has masked it. The host can set a lockout bit before it reads the buffer. While that bit is set, nothing the radio delivers can change the stored contents. A frame too long for the array is dropped. A frame that is cut short never rewrites the length, link-quality or signal-strength bytes.

Top module: `rx_frame_store`

## Requirements
- R1: The buffer is `DEPTH` (144) bytes at host addresses `BUF_BASE` (0x300) to `BUF_BASE+DEPTH-1`. A host read returns its data one cycle after the read strobe. A read at an address that maps to nothing returns 0.
- R2: Frame byte k (counting from 0) of an accepted frame is stored at buffer offset k+1, in arrival order.
- R3: At end of frame, offset 0 receives the number of frame bytes. This count includes the trailing 2-byte checksum, which is ordinary frame data, and excludes the length byte. A frame with no bytes stores length 0.
- R4: At end of a frame of n bytes, the link-quality byte goes to offset n+1 and the signal-strength byte to offset n+2.
- R5: A completed frame sets bit 3 of the status register at `STAT_ADDR`. `rxIrq` is high while that bit is set and not masked. A host read of the status register returns the bit and then clears it.
- R6: Bit 3 of the mask register at `MASK_ADDR` forces `rxIrq` low. The status bit is still set by a completed frame.
- R7: Bit 2 of the control register at `CTRL_ADDR` is the lockout bit and reads back as written. While it is set, no buffer byte changes. A frame during which lockout is seen set stores nothing further and is not completed: no length, link-quality or signal-strength write, and no status.
- R8: A frame that begins while lockout is set is discarded whole, even if lockout clears before its end.
- R9: A frame of more than DEPTH-3 (141) bytes is dropped. Its bytes beyond offset 141 are not stored, offset 0 and the link-quality and signal-strength bytes keep their old values, and no status is raised. A frame of exactly 141 bytes is stored in full.
- R10: The length, link-quality and signal-strength bytes are written only at the end of a frame. A frame that is cut short, with no end pulse or replaced by a new start pulse, leaves them unchanged.
- R11: A data strobe or an end pulse outside a frame has no effect on the buffer or the status.
- R12: After reset every buffer byte, the status, the mask and the lockout bit are 0, and `rxIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxStart | input | 1 | Start-of-frame pulse. Carries no data byte |
| rxValid | input | 1 | A frame data byte is on `rxData` |
| rxData | input | 8 | Frame data byte |
| rxEnd | input | 1 | End-of-frame pulse. Carries no data byte |
| rxLqi | input | 8 | Link-quality byte, valid with `rxEnd` |
| rxRssi | input | 8 | Signal-strength byte, valid with `rxEnd` |
| hostAddr | input | 12 | Host address |
| hostWe | input | 1 | Host write strobe |
| hostRe | input | 1 | Host read strobe |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data, registered |
| rxIrq | output | 1 | Receive interrupt, active high |

## Verification
A data byte lands in the array at the clock edge that samples its strobe. The length, link-quality and signal-strength bytes, the status bit and `rxIrq` all change at the edge that samples `rxEnd`. The bench therefore checks `rxIrq` just after that edge. Read data appears at the edge that samples `hostRe`, and a lockout write takes effect on the next radio strobe. The bench drives and samples one time step after each rising edge, so every result is read one edge after the stimulus that produced it.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int IDX_W = 8;  // buffer index width; DEPTH must stay <= 256

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrByte;
    logic             commit;
    logic [IDX_W-1:0] commitLen;
    logic [7:0]       lqi;
    logic [7:0]       rssi;
  } rfsStrobe_t;
endpackage

// File: rtl/rfs_ctrl.sv
module rfs_ctrl
  import rfs_pkg::*;
#(
  parameter int DEPTH = 144
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxStart,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxEnd,
  input  logic [7:0] rxLqi,
  input  logic [7:0] rxRssi,
  input  logic       lockIn,
  output rfsStrobe_t stb
);
  localparam int MAX_FRAME = DEPTH - 3;
  localparam logic [IDX_W-1:0] MAX_F = IDX_W'(MAX_FRAME);

  logic             active;
  logic             drop;
  logic [IDX_W-1:0] cnt;
  logic             accept;

  assign accept = active && !drop && !lockIn && !rxStart;

  always_comb begin
    stb           = '0;
    stb.wrEn      = accept && rxValid && !rxEnd && (cnt < MAX_F);
    stb.wrIdx     = cnt + 1'b1;
    stb.wrByte    = rxData;
    stb.commit    = accept && rxEnd && (cnt <= MAX_F);
    stb.commitLen = cnt;
    stb.lqi       = rxLqi;
    stb.rssi      = rxRssi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      drop   <= 1'b0;
      cnt    <= '0;
    end else if (rxStart) begin
      active <= 1'b1;
      drop   <= lockIn;
      cnt    <= '0;
    end else if (active) begin
      drop <= drop | lockIn;
      if (rxEnd) active <= 1'b0;
      else if (rxValid && cnt <= MAX_F) cnt <= cnt + 1'b1;
    end
  end

  // R2: data bytes only ever land between offset 1 and the last frame slot
  a_r2_data_window: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |-> (stb.wrIdx >= 1 && stb.wrIdx <= MAX_F));
  // R8: a discarded frame emits neither byte writes nor a commit
  a_r8_drop_silent: assert property (@(posedge clk) disable iff (!rstN)
    (active && drop && !rxStart) |-> !(stb.wrEn || stb.commit));
  // R9: an over-long frame is never committed
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> stb.commitLen <= MAX_F);
endmodule

// File: rtl/rfs_data.sv
module rfs_data
  import rfs_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int ADDR_W = 12,
  parameter int BUF_BASE = 'h300,
  parameter int CTRL_ADDR = 'h010,
  parameter int STAT_ADDR = 'h011,
  parameter int MASK_ADDR = 'h012,
  parameter int LOCK_BIT = 2,
  parameter int RX_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfsStrobe_t        stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              lockOut,
  output logic              rxIrq
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BUF_BASE);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_ADDR);

  logic [7:0]        mem [DEPTH];
  logic              lockReg, maskReg, rxDone;
  logic [ADDR_W-1:0] offs;
  logic              inBuf;
  logic [7:0]        rdNext;

  assign offs  = hostAddr - BASE_A;
  assign inBuf = (hostAddr >= BASE_A) && (offs < ADDR_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (stb.wrEn) mem[stb.wrIdx] <= stb.wrByte;
      if (stb.commit) begin
        mem[0]                    <= stb.commitLen;
        mem[stb.commitLen + 8'd1] <= stb.lqi;
        mem[stb.commitLen + 8'd2] <= stb.rssi;
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (inBuf)                  rdNext = mem[offs[IDX_W-1:0]];
    else if (hostAddr == CTRL_A) rdNext[LOCK_BIT] = lockReg;
    else if (hostAddr == STAT_A) rdNext[RX_BIT] = rxDone;
    else if (hostAddr == MASK_A) rdNext[RX_BIT] = maskReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockReg    <= 1'b0;
      maskReg    <= 1'b0;
      rxDone     <= 1'b0;
      hostRdData <= '0;
    end else begin
      if (hostWe && hostAddr == CTRL_A) lockReg <= hostWrData[LOCK_BIT];
      if (hostWe && hostAddr == MASK_A) maskReg <= hostWrData[RX_BIT];
      if (hostRe) hostRdData <= rdNext;
      if (stb.commit) rxDone <= 1'b1;
      else if (hostRe && hostAddr == STAT_A) rxDone <= 1'b0;
    end
  end

  assign lockOut = lockReg;
  assign rxIrq   = rxDone && !maskReg;

  // R5: status rises only after a committed frame
  a_r5_done_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(stb.commit));
  // R7: while locked, the control side issues no buffer writes
  a_r7_lock_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockReg |-> !(stb.wrEn || stb.commit));
  // R10: the length byte moves only on a commit
  a_r10_len_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mem[0]) |-> $past(stb.commit));
endmodule

// File: rtl/rx_frame_store.sv
module rx_frame_store
  import rfs_pkg::*;
#(
  parameter int DEPTH = 144,
  parameter int ADDR_W = 12,
  parameter int BUF_BASE = 'h300,
  parameter int CTRL_ADDR = 'h010,
  parameter int STAT_ADDR = 'h011,
  parameter int MASK_ADDR = 'h012
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxStart,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxEnd,
  input  logic [7:0]        rxLqi,
  input  logic [7:0]        rxRssi,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWe,
  input  logic              hostRe,
  input  logic [7:0]        hostWrData,
  output logic [7:0]        hostRdData,
  output logic              rxIrq
);
  rfsStrobe_t stb;
  logic       lockLine;

  rfs_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxValid(rxValid),
    .rxData(rxData), .rxEnd(rxEnd), .rxLqi(rxLqi), .rxRssi(rxRssi),
    .lockIn(lockLine), .stb(stb)
  );

  rfs_data #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BUF_BASE(BUF_BASE),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr), .hostWe(hostWe),
    .hostRe(hostRe), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .lockOut(lockLine), .rxIrq(rxIrq)
  );
endmodule

// File: tb/tb_rx_frame_store.sv
`timescale 1ns/1ps
module tb_rx_frame_store;
  localparam int DEPTH = 144;
  localparam int MAXF  = DEPTH - 3;
  localparam logic [11:0] BASE = 12'h300;
  localparam logic [11:0] CTRL = 12'h010;
  localparam logic [11:0] STAT = 12'h011;
  localparam logic [11:0] MASK = 12'h012;

  logic clk = 1'b0;
  logic rstN, rxStart, rxValid, rxEnd, hostWe, hostRe, rxIrq;
  logic [7:0] rxData, rxLqi, rxRssi, hostWrData, hostRdData;
  logic [11:0] hostAddr;

  always #5 clk = ~clk;

  rx_frame_store dut (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxValid(rxValid),
    .rxData(rxData), .rxEnd(rxEnd), .rxLqi(rxLqi), .rxRssi(rxRssi),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostRe(hostRe),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .rxIrq(rxIrq)
  );

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] model [DEPTH];
  bit modelLock = 0;
  logic [7:0] frm [256];
  logic [7:0] rd;
  bit committed;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic [11:0] a, logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWe = 1'b1;
    tick();
    hostWe = 1'b0;
  endtask

  task automatic hostRead(logic [11:0] a, output logic [7:0] d);
    hostAddr = a; hostRe = 1'b1;
    tick();
    hostRe = 1'b0;
    d = hostRdData;
  endtask

  task automatic compareBuf(string tag);
    int bad = 0;
    int firstIdx = 0;
    logic [7:0] firstAct = 0;
    logic [7:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(BASE + 12'(i), d);
      if (d !== model[i]) begin
        if (bad == 0) begin firstIdx = i; firstAct = d; end
        bad++;
      end
    end
    nChecks++;
    if (bad != 0) begin
      nFails++;
      $display("FAIL %s offset %0d actual=%0h expected=%0h (%0d bytes differ)",
               tag, firstIdx, firstAct, model[firstIdx], bad);
    end
  endtask

  // setAt / clrAt: lockout written before data byte k (k == n means before the end pulse)
  task automatic sendFrame(int n, int setAt, int clrAt, output bit done);
    logic [7:0] lqi, rssi;
    bit drop;
    lqi = 8'($urandom);
    rssi = 8'($urandom);
    for (int i = 0; i < n; i++) frm[i] = 8'($urandom);
    rxStart = 1'b1;
    tick();
    rxStart = 1'b0;
    drop = modelLock;
    for (int k = 0; k <= n; k++) begin
      if (k == setAt) begin hostWrite(CTRL, 8'h04); modelLock = 1; drop = 1; end
      if (k == clrAt) begin hostWrite(CTRL, 8'h00); modelLock = 0; end
      if (k < n) begin
        rxValid = 1'b1; rxData = frm[k];
        tick();
        rxValid = 1'b0;
        if (!drop && k < MAXF) model[k+1] = frm[k];
      end
    end
    rxEnd = 1'b1; rxLqi = lqi; rxRssi = rssi;
    tick();
    rxEnd = 1'b0;
    done = !drop && n <= MAXF;
    if (done) begin
      model[0] = 8'(n);
      model[n+1] = lqi;
      model[n+2] = rssi;
    end
  endtask

  task automatic checkStat(string tag, bit exp);
    logic [7:0] d;
    hostRead(STAT, d);
    check(tag, d, exp ? 8'h08 : 8'h00);
  endtask

  initial begin
    rstN = 0; rxStart = 0; rxValid = 0; rxEnd = 0; rxData = 0; rxLqi = 0; rxRssi = 0;
    hostAddr = 0; hostWe = 0; hostRe = 0; hostWrData = 0;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) tick();
    rstN = 1;
    tick();

    // R12: reset state
    check("R12 irq", rxIrq, 0);
    checkStat("R12 status", 0);
    hostRead(CTRL, rd); check("R12 lockout", rd, 0);
    hostRead(MASK, rd); check("R12 mask", rd, 0);
    compareBuf("R12 buffer");

    // R2 R3 R4 R5: plain frame
    sendFrame(5, -1, -1, committed);
    check("R5 irq after end", rxIrq, 1);
    compareBuf("R2 R3 R4 frame of 5");
    checkStat("R5 status set", 1);
    check("R5 irq cleared by read", rxIrq, 0);
    checkStat("R5 status cleared", 0);

    // R1: address map
    hostRead(BASE, rd); check("R1 base holds length", rd, 5);
    hostRead(BASE + 12'(DEPTH), rd); check("R1 past end", rd, 0);
    hostRead(BASE - 12'd1, rd); check("R1 below base", rd, 0);

    // R6: mask
    hostWrite(MASK, 8'h08);
    sendFrame(7, -1, -1, committed);
    check("R6 irq masked", rxIrq, 0);
    checkStat("R6 status still set", 1);
    hostWrite(MASK, 8'h00);

    // R7: lockout held for a whole frame
    hostWrite(CTRL, 8'h04); modelLock = 1;
    hostRead(CTRL, rd); check("R7 lockout readback", rd, 8'h04);
    sendFrame(6, -1, -1, committed);
    check("R7 irq", rxIrq, 0);
    compareBuf("R7 buffer frozen");
    checkStat("R7 no status", 0);

    // R8: started locked, lockout cleared midway
    sendFrame(4, -1, 2, committed);
    compareBuf("R8 buffer");
    checkStat("R8 no status", 0);

    // R7: lockout set partway through a frame
    sendFrame(8, 3, -1, committed);
    compareBuf("R7 mid-frame lock");
    checkStat("R7 mid-frame no status", 0);
    hostWrite(CTRL, 8'h00); modelLock = 0;

    // R9: overflow and boundaries
    sendFrame(150, -1, -1, committed);
    compareBuf("R9 overflow 150");
    checkStat("R9 overflow no status", 0);
    sendFrame(MAXF, -1, -1, committed);
    compareBuf("R9 exact 141");
    checkStat("R9 exact status", 1);
    sendFrame(MAXF + 1, -1, -1, committed);
    compareBuf("R9 overflow 142");
    checkStat("R9 142 no status", 0);

    // R3: empty frame
    sendFrame(0, -1, -1, committed);
    compareBuf("R3 empty frame");
    checkStat("R3 empty status", 1);

    // R10: truncated frame leaves length/lqi/rssi
    rxStart = 1; tick(); rxStart = 0;
    for (int k = 0; k < 4; k++) begin
      rxValid = 1; rxData = 8'(8'hC0 + k); tick(); rxValid = 0;
      model[k+1] = 8'(8'hC0 + k);
    end
    compareBuf("R10 truncated");
    checkStat("R10 truncated no status", 0);
    sendFrame(3, -1, -1, committed);
    compareBuf("R10 restart then complete");
    checkStat("R10 status", 1);

    // R11: stray strobes outside a frame
    rxValid = 1; rxData = 8'hAA; tick(); rxValid = 0;
    rxEnd = 1; rxLqi = 8'h11; rxRssi = 8'h22; tick(); rxEnd = 0;
    check("R11 irq", rxIrq, 0);
    compareBuf("R11 buffer");
    checkStat("R11 no status", 0);

    // Random frames (R2 R3 R4 R5 R7 R9)
    for (int t = 0; t < 20; t++) begin
      int n;
      int setAt;
      n = $urandom_range(0, 150);
      setAt = ($urandom_range(0, 4) == 0) ? $urandom_range(0, n) : -1;
      sendFrame(n, setAt, -1, committed);
      check("R5 random irq", rxIrq, committed);
      compareBuf("R2 R3 R4 R9 random");
      checkStat("R5 random status", committed);
      if (modelLock) begin hostWrite(CTRL, 8'h00); modelLock = 0; end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule